// File: doc/BRIEF.md
# Fixed-Point Radix-2 Butterfly

This block computes one radix-2 decimation-in-time butterfly for a fixed-point FFT. Each accepted input holds two complex operands, A and B, and one complex twiddle W. The block forms T = B·W and returns X = (A + T)/2 and Y = (A − T)/2. Every component uses the input word width, so identical stages can be chained to build transforms whose size is a power of two.

The twiddle is a signed fraction with the binary point just right of the sign bit. Each of the four partial products B·W is returned to data scale by rounding half away from zero, which avoids the DC drift that truncation causes. The sums are halved to absorb the growth of one bit. A result that is still outside the word range is clamped, and a flag then stays raised until reset. Each input beat is marked by a valid strobe. The matching result appears a fixed three cycles later with its own valid strobe, and inputs may arrive back to back.

Top module: `bfly_radix2`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0, `ovf_sticky` is 0 and all four result components are 0.
- R2: `out_valid` equals `in_valid` delayed by exactly three clock cycles. Inputs may be presented on consecutive cycles, and every accepted beat produces exactly one result.
- R3: Each partial product (b_re·w_re, b_im·w_im, b_re·w_im, b_im·w_re) is scaled down by 2^15. The scaling rounds half away from zero: for p ≥ 0 the term is floor((p + 2^14)/2^15), and for p < 0 it is −floor((−p + 2^14)/2^15). Then t_re = rr − ii and t_im = ri + ir.
- R4: x_re = (a_re + t_re) >>> 1 and x_im = (a_im + t_im) >>> 1, before clamping.
- R5: y_re = (a_re − t_re) >>> 1 and y_im = (a_im − t_im) >>> 1, before clamping. The halving is an arithmetic shift, so odd negative sums round toward minus infinity.
- R6: A halved result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R7: `ovf_sticky` rises in the same cycle as the first clamped result is presented. It then stays high until reset, whatever the later inputs are.
- R8: While `out_valid` is 0, all four result outputs hold their previous values.
- R9: The twiddle code 0x8000 (−1) negates B exactly, including B = −32768. The twiddle code 0 gives X = Y = A >>> 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks an input beat |
| a_re | input | 16 | Operand A, real part, signed |
| a_im | input | 16 | Operand A, imaginary part, signed |
| b_re | input | 16 | Operand B, real part, signed |
| b_im | input | 16 | Operand B, imaginary part, signed |
| w_re | input | 16 | Twiddle, real part, signed fraction |
| w_im | input | 16 | Twiddle, imaginary part, signed fraction |
| out_valid | output | 1 | Marks a result beat |
| x_re | output | 16 | Sum output, real part |
| x_im | output | 16 | Sum output, imaginary part |
| y_re | output | 16 | Difference output, real part |
| y_im | output | 16 | Difference output, imaginary part |
| ovf_sticky | output | 1 | Set by any clamped result, cleared only by reset |

## Verification
The bound checker checks these timing and control properties on every cycle:
- the three-cycle valid delay;
- the outputs holding still between results;
- any clamped lane showing exactly the most positive or most negative code;
- the overflow flag being raised with that lane and never dropping.

Only the bench's scenarios can show that the numbers themselves are right. Each result is compared bit for bit with an independent integer model. The directed cases are:
- half-way rounding ties of both signs;
- twiddles of about +1, exactly −1, zero and ±j;
- floor halving of odd negative sums;
- a B of −32768 against a −1 twiddle;
- a full-scale combination that must clamp.

A random stream with idle gaps completes the stimulus.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // Pipeline depth from an accepted input beat to its result.
  localparam int unsigned BFLY_LAT = 3;
  // Default component width for data and twiddle.
  localparam int unsigned BFLY_DW_DEF = 16;
endpackage

// File: rtl/bfly_valid_pipe.sv
module bfly_valid_pipe #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vin,
  output logic [DEPTH-1:0] vstage
);
  always_ff @(posedge clk) begin
    if (rst) vstage[0] <= 1'b0;
    else     vstage[0] <= vin;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vstage[i] <= 1'b0;
      else     vstage[i] <= vstage[i-1];
    end
  end
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_mul,
  input  logic                 en_rnd,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [DW+1:0] t_re,
  output logic signed [DW+1:0] t_im
);
  localparam int PW  = DW + TW;
  localparam int RW  = DW + 1;
  localparam int SH  = TW - 1;
  localparam int TSW = DW + 2;
  localparam logic signed [PW:0] HALF = {{(PW+1-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};

  function automatic logic signed [PW-1:0] smul(input logic signed [DW-1:0] x,
                                                input logic signed [TW-1:0] y);
    return PW'(x) * PW'(y);
  endfunction

  // Round half away from zero while dropping SH fraction bits.
  function automatic logic signed [RW-1:0] rnd_sym(input logic signed [PW-1:0] p);
    logic signed [PW:0]   mag;
    logic signed [RW-1:0] q;
    mag = p[PW-1] ? -((PW+1)'(p)) : (PW+1)'(p);
    q   = RW'((mag + HALF) >>> SH);
    return p[PW-1] ? -q : q;
  endfunction

  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;

  // Stage 1: raw products.
  always_ff @(posedge clk) begin
    if (rst) begin
      p_rr <= '0; p_ii <= '0; p_ri <= '0; p_ir <= '0;
    end else if (en_mul) begin
      p_rr <= smul(b_re, w_re);
      p_ii <= smul(b_im, w_im);
      p_ri <= smul(b_re, w_im);
      p_ir <= smul(b_im, w_re);
    end
  end

  // Stage 2: round each term, then combine into the complex product.
  always_ff @(posedge clk) begin
    if (rst) begin
      t_re <= '0; t_im <= '0;
    end else if (en_rnd) begin
      t_re <= TSW'(rnd_sym(p_rr)) - TSW'(rnd_sym(p_ii));
      t_im <= TSW'(rnd_sym(p_ri)) + TSW'(rnd_sym(p_ir));
    end
  end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW+1:0] t_re,
  input  logic signed [DW+1:0] t_im,
  output logic signed [DW-1:0] x_re,
  output logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im,
  output logic [3:0]           sat_now,
  output logic [3:0]           sat_q
);
  localparam int SW = DW + 3;
  localparam logic signed [DW-1:0] VMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] VMIN = {1'b1, {(DW-1){1'b0}}};

  // Halve by arithmetic shift, then clamp; the top bit flags a clamp.
  function automatic logic [DW:0] halve_sat(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] h;
    logic [SW-DW:0]       top;
    h   = s >>> 1;
    top = h[SW-1:DW-1];
    if ((&top) || !(|top)) return {1'b0, h[DW-1:0]};
    return {1'b1, (h[SW-1] ? VMIN : VMAX)};
  endfunction

  logic signed [SW-1:0] sum_w  [4];
  logic [DW:0]          fold_w [4];
  logic signed [DW-1:0] res_q  [4];

  // Lanes: 0 x_re, 1 x_im, 2 y_re, 3 y_im.
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic signed [SW-1:0] oa, ot;
    assign oa        = ((k % 2) == 0) ? SW'(a_re) : SW'(a_im);
    assign ot        = ((k % 2) == 0) ? SW'(t_re) : SW'(t_im);
    assign sum_w[k]  = (k < 2) ? (oa + ot) : (oa - ot);
    assign fold_w[k] = halve_sat(sum_w[k]);
    assign sat_now[k] = fold_w[k][DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) res_q[k] <= '0;
      sat_q <= '0;
    end else if (en) begin
      for (int k = 0; k < 4; k++) res_q[k] <= fold_w[k][DW-1:0];
      sat_q <= sat_now;
    end
  end

  assign x_re = res_q[0];
  assign x_im = res_q[1];
  assign y_re = res_q[2];
  assign y_im = res_q[3];
endmodule

// File: rtl/bfly_radix2.sv
module bfly_radix2
  import bfly_pkg::*;
#(
  parameter int DW = BFLY_DW_DEF,
  parameter int TW = BFLY_DW_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] x_re,
  output logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im,
  output logic                 ovf_sticky
);
  localparam int TSW = DW + 2;

  logic [BFLY_LAT-1:0]   vpipe;
  logic signed [DW-1:0]  a_re_d [2];
  logic signed [DW-1:0]  a_im_d [2];
  logic signed [TSW-1:0] t_re, t_im;
  logic [3:0]            sat_now;
  logic [3:0]            sat_q;

  bfly_valid_pipe #(.DEPTH(BFLY_LAT)) u_vld (
    .clk    (clk),
    .rst    (rst),
    .vin    (in_valid),
    .vstage (vpipe)
  );

  // Operand A waits two stages alongside the multiplier.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_re_d <= '{default: '0};
      a_im_d <= '{default: '0};
    end else begin
      if (in_valid) begin
        a_re_d[0] <= a_re;
        a_im_d[0] <= a_im;
      end
      if (vpipe[0]) begin
        a_re_d[1] <= a_re_d[0];
        a_im_d[1] <= a_im_d[0];
      end
    end
  end

  bfly_cmul #(.DW(DW), .TW(TW)) u_cmul (
    .clk    (clk),
    .rst    (rst),
    .en_mul (in_valid),
    .en_rnd (vpipe[0]),
    .b_re   (b_re),
    .b_im   (b_im),
    .w_re   (w_re),
    .w_im   (w_im),
    .t_re   (t_re),
    .t_im   (t_im)
  );

  bfly_addsub #(.DW(DW)) u_addsub (
    .clk     (clk),
    .rst     (rst),
    .en      (vpipe[1]),
    .a_re    (a_re_d[1]),
    .a_im    (a_im_d[1]),
    .t_re    (t_re),
    .t_im    (t_im),
    .x_re    (x_re),
    .x_im    (x_im),
    .y_re    (y_re),
    .y_im    (y_im),
    .sat_now (sat_now),
    .sat_q   (sat_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                          ovf_sticky <= 1'b0;
    else if (vpipe[1] && (|sat_now))  ovf_sticky <= 1'b1;
  end

  assign out_valid = vpipe[BFLY_LAT-1];
endmodule

// File: rtl/bfly_radix2_chk.sv
module bfly_radix2_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] x_re,
  input logic signed [DW-1:0] x_im,
  input logic signed [DW-1:0] y_re,
  input logic signed [DW-1:0] y_im,
  input logic                 ovf_sticky,
  input logic [3:0]           sat_q
);
  localparam logic signed [DW-1:0] VMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] VMIN = {1'b1, {(DW-1){1'b0}}};

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst)                 since <= 2'd0;
    else if (since != 2'd3)  since <= since + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !ovf_sticky && x_re == '0 && x_im == '0 &&
                    y_re == '0 && y_im == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable({x_re, x_im, y_re, y_im}));

  assert_clamp_value_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((!sat_q[0] || x_re == VMAX || x_re == VMIN) &&
                   (!sat_q[1] || x_im == VMAX || x_im == VMIN) &&
                   (!sat_q[2] || y_re == VMAX || y_re == VMIN) &&
                   (!sat_q[3] || y_im == VMAX || y_im == VMIN)));

  assert_flag_on_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (|sat_q)) |-> ovf_sticky);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_sticky |=> ovf_sticky);
endmodule

bind bfly_radix2 bfly_radix2_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .x_re       (x_re),
  .x_im       (x_im),
  .y_re       (y_re),
  .y_im       (y_im),
  .ovf_sticky (ovf_sticky),
  .sat_q      (sat_q)
);

// File: tb/bfly_radix2_tb.sv
`timescale 1ns/1ps
module bfly_radix2_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
  logic out_valid, ovf_sticky;
  logic signed [15:0] x_re, x_im, y_re, y_im;

  always #5 clk = ~clk;

  bfly_radix2 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .out_valid(out_valid), .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .ovf_sticky(ovf_sticky)
  );

  typedef struct {
    int     xr, xi, yr, yi;
    bit     sat;
    longint due;
    string  tag;
  } item_t;

  item_t  sb[$];
  item_t  last;
  bit     have_last = 0;
  bit     prev_ov   = 0;
  bit     exp_ovf   = 0;
  bit     finished  = 0;
  longint cyc = 0;
  int     n_chk = 0, n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // Reference model, written from the requirements.
  function automatic longint q15_round(longint p);
    if (p >= 0) return (p + 16384) / 32768;
    return -((16384 - p) / 32768);
  endfunction

  function automatic int clamp_half(longint s, ref bit hit);
    longint h;
    h = s >>> 1;
    if (h > 32767)  begin hit = 1; return 32767;  end
    if (h < -32768) begin hit = 1; return -32768; end
    return int'(h);
  endfunction

  task automatic send(int ar, int ai, int br, int bi, int wr, int wi, string tag);
    item_t  it;
    longint tr, ti;
    bit     hit;
    @(negedge clk);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    w_re = 16'(wr); w_im = 16'(wi);
    in_valid = 1'b1;
    tr = q15_round(longint'(br) * wr) - q15_round(longint'(bi) * wi);
    ti = q15_round(longint'(br) * wi) + q15_round(longint'(bi) * wr);
    hit = 0;
    it.xr = clamp_half(longint'(ar) + tr, hit);
    it.xi = clamp_half(longint'(ai) + ti, hit);
    it.yr = clamp_half(longint'(ar) - tr, hit);
    it.yi = clamp_half(longint'(ai) - ti, hit);
    it.sat = hit;
    it.due = cyc + 3;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares each result with the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk("R2", "unexpected out_valid", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk("R2", {it.tag, " latency cycle"}, cyc, it.due);
          chk("R4", {it.tag, " x_re"}, x_re, it.xr);
          chk("R4", {it.tag, " x_im"}, x_im, it.xi);
          chk("R5", {it.tag, " y_re"}, y_re, it.yr);
          chk("R5", {it.tag, " y_im"}, y_im, it.yi);
          exp_ovf = exp_ovf | it.sat;
          chk("R7", {it.tag, " ovf_sticky"}, ovf_sticky, exp_ovf);
          last = it;
          have_last = 1;
        end
      end else if (prev_ov && have_last) begin
        chk("R8", "hold x_re", x_re, last.xr);
        chk("R8", "hold y_im", y_im, last.yi);
      end
      prev_ov = out_valid;
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "ovf_sticky after reset", ovf_sticky, 0);
    chk("R1", "x_re after reset", x_re, 0);
    chk("R1", "y_im after reset", y_im, 0);

    // R3/R4: twiddle close to +1
    send(1000, -2000, 3000, 4000, 32767, 0, "R3 w~+1");
    // R9: twiddle exactly -1 with B at full-scale negative
    send(0, 0, -32768, 12345, -32768, 0, "R9 w=-1");
    // R9 and R5: zero twiddle, odd negative A halved by floor
    send(-3, 5, 20000, -20000, 0, 0, "R9 w=0");
    // R3: twiddles +j and -j
    send(100, 200, 300, -400, 0, 32767, "R3 w=+j");
    send(100, 200, 300, -400, 0, -32768, "R3 w=-j");
    idle(2);
    // R3: half-way rounding ties of both signs (w = 0.5)
    send(0, 0, 3, -3, 16384, 0, "R3 tie");
    send(7, -7, -3, 3, 16384, 16384, "R3 tie mix");
    // R5: odd negative difference
    send(-32768, -32767, 1, 1, 32767, 32767, "R5 floor");
    idle(3);

    // R2: random stream with gaps, bounded so it cannot clamp
    for (int i = 0; i < 60; i++) begin
      send(int'($urandom_range(32767, 0)) - 16384, int'($urandom_range(32767, 0)) - 16384,
           int'($urandom_range(32767, 0)) - 16384, int'($urandom_range(32767, 0)) - 16384,
           int'($urandom_range(65535, 0)) - 32768, int'($urandom_range(65535, 0)) - 32768,
           "R2 stream");
      if (i % 7 == 3) idle(1 + i % 3);
    end
    idle(6);

    // R6/R7: full-scale inputs that must clamp, then a quiet one
    send(32767, -32768, -32768, -32768, -32768, 32767, "R6 clamp");
    send(-32768, 32767, 32767, -32768, 32767, 32767, "R6 clamp2");
    send(10, 10, 10, 10, 0, 0, "R7 after clamp");
    idle(6);

    chk("R2", "scoreboard drained", sb.size(), 0);
    chk("R7", "flag still high", ovf_sticky, 1);
    chk("R8", "idle hold x_im", x_im, last.xi);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule